// File: doc/BRIEF.md
# Pin Function Mux and Pad Control

This block controls a single I/O pad. A control word picks which function owns the pad, the bias applied when nothing drives it, the output drive current and the GPIO output enable. A second word carries the GPIO output level and shows the synchronized pad input. Function 0 hands the pad to the GPIO path. Functions 1 to 7 each hand it to one of seven alternate-function sources, which supply their own output-enable and data.

From these settings the block produces the pad driver controls: enable, data, drive code and the three bias controls. It also produces a modelled pad level for the case where nothing drives the pad. Pull-down and pull-up give a fixed level. Keeper repeats the last level the pad held. No pull leaves the level undefined, and this is flagged by a valid bit.

Drive strength is requested in milliamperes. Only even currents from 2 to 16 mA are accepted. Any other request leaves the stored drive code untouched, while the other fields of the same write still take effect.

Top module: `pinpad_ctrl`

## Requirements
- R1: After reset the control word reads 0x0048: function 0, bias pull-down (1), drive 2 mA (code 0) and output enable 0. The pad is undriven and its modelled level is a valid 0.
- R2: The control word layout is function in bits [2:0], bias in bits [4:3], drive current in mA in bits [9:5] and GPIO output enable in bit 10. With function 0, pad_oe follows the enable bit and pad_out follows I/O word bit 0.
- R3: With function f from 1 to 7, pad_oe equals alt_oe[f-1] and pad_out equals alt_out[f-1]. The GPIO enable and output bits have no effect.
- R4: A legal drive request of m mA (m even, 2 to 16) sets pad_drv to m/2-1. The control word then reads back m in bits [9:5].
- R5: A drive request that is odd, 0 or above 16 leaves pad_drv and the read-back current unchanged. Function, bias and enable from the same write are still stored.
- R6: When the pad is undriven, bias 1 (pull-down) gives a valid level of 0 and bias 3 (pull-up) gives a valid level of 1.
- R7: When the pad is undriven with bias 2 (keeper), the modelled level stays at the last valid level the pad had.
- R8: When the pad is undriven with bias 0 (no pull), pad_val_valid is 0.
- R9: pad_in passes through a two-stage synchronizer to in_sync and to I/O word bit 1, under any selected function.
- R10: I/O word bit 1 is read-only. Writing it has no effect on the value read back.
- R11: While pad_oe is 1, pad_val equals pad_out and pad_val_valid is 1.
- R12: pad_pull_down, pad_keep and pad_pull_up decode bias values 1, 2 and 3, and at most one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control word, 1 selects the I/O word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| alt_oe | input | 7 | Output enables of alternate functions 1..7 |
| alt_out | input | 7 | Output data of alternate functions 1..7 |
| pad_in | input | 1 | Level seen at the pad receiver |
| in_sync | output | 1 | Synchronized pad input |
| pad_oe | output | 1 | Pad driver enable |
| pad_out | output | 1 | Pad driver data |
| pad_drv | output | 3 | Drive strength code |
| pad_pull_up | output | 1 | Pull-up enable |
| pad_pull_down | output | 1 | Pull-down enable |
| pad_keep | output | 1 | Keeper enable |
| pad_val | output | 1 | Modelled pad level |
| pad_val_valid | output | 1 | Modelled pad level is defined |

## Verification
Two things happen in the same cycle when a single control write carries an illegal drive current alongside a new function and bias: the field update and the drive rejection. The bench issues such writes with currents of 5, 0 and 18 mA and then reads the word back. It expects the new function and bias next to the old current, and an unchanged pad_drv. A second case is the keeper capture on the same edge that releases the driver. The bench releases a driven pad and expects the modelled level to keep the driven value, even after the GPIO output bit is later changed.

// File: rtl/pinpad_pkg.sv
package pinpad_pkg;

    parameter int FUNC_W = 3;
    parameter int DRV_W  = 3;
    parameter int DATA_W = 16;

    localparam int NUM_FUNC = 1 << FUNC_W;
    localparam int NUM_ALT  = NUM_FUNC - 1;
    localparam int MAX_MA   = 2 * (1 << DRV_W);
    localparam int MA_W     = $clog2(MAX_MA + 1);

    // control word field positions
    localparam int F_FUNC_LSB = 0;
    localparam int F_BIAS_LSB = F_FUNC_LSB + FUNC_W;
    localparam int F_MA_LSB   = F_BIAS_LSB + 2;
    localparam int F_OE_BIT   = F_MA_LSB + MA_W;

    // I/O word bit positions
    localparam int IO_OUT_BIT = 0;
    localparam int IO_IN_BIT  = 1;

    typedef enum logic [1:0] {
        BIAS_NONE = 2'd0,
        BIAS_DOWN = 2'd1,
        BIAS_KEEP = 2'd2,
        BIAS_UP   = 2'd3
    } bias_e;

    typedef struct packed {
        logic              oe;
        logic [DRV_W-1:0]  drv;
        bias_e             bias;
        logic [FUNC_W-1:0] func;
    } pad_cfg_t;

    function automatic logic ma_is_legal(input logic [MA_W-1:0] ma);
        return (ma != '0) && !ma[0] && (int'(ma) <= MAX_MA);
    endfunction

    function automatic logic [DRV_W-1:0] code_from_ma(input logic [MA_W-1:0] ma);
        logic [MA_W-1:0] half;
        half = (ma >> 1) - MA_W'(1);
        return half[DRV_W-1:0];
    endfunction

    function automatic logic [MA_W-1:0] ma_from_code(input logic [DRV_W-1:0] code);
        return (MA_W'(code) << 1) + MA_W'(2);
    endfunction

endpackage

// File: rtl/pinpad_regs.sv
module pinpad_regs
    import pinpad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              in_sync,
    output pad_cfg_t          cfg,
    output logic              gpio_out,
    output logic [DATA_W-1:0] rdata
);

    logic [MA_W-1:0] req_ma;
    assign req_ma = wdata[F_MA_LSB +: MA_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.func <= '0;
            cfg.bias <= BIAS_DOWN;
            cfg.drv  <= '0;
            cfg.oe   <= 1'b0;
            gpio_out <= 1'b0;
        end else if (wr_en) begin
            if (!addr) begin
                cfg.func <= wdata[F_FUNC_LSB +: FUNC_W];
                cfg.bias <= bias_e'(wdata[F_BIAS_LSB +: 2]);
                cfg.oe   <= wdata[F_OE_BIT];
                if (ma_is_legal(req_ma))
                    cfg.drv <= code_from_ma(req_ma);
            end else begin
                gpio_out <= wdata[IO_OUT_BIT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (!addr) begin
            rdata[F_FUNC_LSB +: FUNC_W] = cfg.func;
            rdata[F_BIAS_LSB +: 2]      = cfg.bias;
            rdata[F_MA_LSB +: MA_W]     = ma_from_code(cfg.drv);
            rdata[F_OE_BIT]             = cfg.oe;
        end else begin
            rdata[IO_OUT_BIT] = gpio_out;
            rdata[IO_IN_BIT]  = in_sync;
        end
    end

endmodule

// File: rtl/pinpad_mux.sv
module pinpad_mux
    import pinpad_pkg::*;
(
    input  logic [FUNC_W-1:0]  func,
    input  logic               gpio_oe,
    input  logic               gpio_out,
    input  logic [NUM_ALT-1:0] alt_oe,
    input  logic [NUM_ALT-1:0] alt_out,
    output logic               pad_oe,
    output logic               pad_out
);

    logic [NUM_FUNC-1:0] oe_src;
    logic [NUM_FUNC-1:0] out_src;

    assign oe_src[0]  = gpio_oe;
    assign out_src[0] = gpio_out;

    for (genvar g = 1; g < NUM_FUNC; g++) begin : g_alt
        assign oe_src[g]  = alt_oe[g-1];
        assign out_src[g] = alt_out[g-1];
    end

    assign pad_oe  = oe_src[func];
    assign pad_out = out_src[func];

endmodule

// File: rtl/pinpad_resolve.sv
module pinpad_resolve
    import pinpad_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  bias_e bias,
    input  logic  pad_oe,
    input  logic  pad_out,
    output logic  pull_up,
    output logic  pull_down,
    output logic  keep,
    output logic  pad_val,
    output logic  pad_val_valid
);

    logic kept;

    assign pull_up   = (bias == BIAS_UP);
    assign pull_down = (bias == BIAS_DOWN);
    assign keep      = (bias == BIAS_KEEP);

    always_comb begin
        pad_val       = 1'b0;
        pad_val_valid = 1'b1;
        if (pad_oe) begin
            pad_val = pad_out;
        end else begin
            unique case (bias)
                BIAS_DOWN: pad_val = 1'b0;
                BIAS_UP:   pad_val = 1'b1;
                BIAS_KEEP: pad_val = kept;
                BIAS_NONE: pad_val_valid = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            kept <= 1'b0;
        else if (pad_val_valid)
            kept <= pad_val;
    end

endmodule

// File: rtl/pinpad_sync.sv
module pinpad_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pinpad_ctrl.sv
module pinpad_ctrl
    import pinpad_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_ALT-1:0] alt_oe,
    input  logic [NUM_ALT-1:0] alt_out,
    input  logic               pad_in,
    output logic               in_sync,
    output logic               pad_oe,
    output logic               pad_out,
    output logic [DRV_W-1:0]   pad_drv,
    output logic               pad_pull_up,
    output logic               pad_pull_down,
    output logic               pad_keep,
    output logic               pad_val,
    output logic               pad_val_valid
);

    pad_cfg_t cfg;
    logic     gpio_out;

    pinpad_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (in_sync)
    );

    pinpad_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .in_sync  (in_sync),
        .cfg      (cfg),
        .gpio_out (gpio_out),
        .rdata    (reg_rdata)
    );

    pinpad_mux u_mux (
        .func     (cfg.func),
        .gpio_oe  (cfg.oe),
        .gpio_out (gpio_out),
        .alt_oe   (alt_oe),
        .alt_out  (alt_out),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out)
    );

    pinpad_resolve u_res (
        .clk           (clk),
        .rst           (rst),
        .bias          (cfg.bias),
        .pad_oe        (pad_oe),
        .pad_out       (pad_out),
        .pull_up       (pad_pull_up),
        .pull_down     (pad_pull_down),
        .keep          (pad_keep),
        .pad_val       (pad_val),
        .pad_val_valid (pad_val_valid)
    );

    assign pad_drv = cfg.drv;

endmodule

// File: rtl/pinpad_ctrl_chk.sv
module pinpad_ctrl_chk
    import pinpad_pkg::*;
#(
    parameter int STAGES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              pad_in,
    input logic              in_sync,
    input logic              pad_oe,
    input logic              pad_out,
    input logic [DRV_W-1:0]  pad_drv,
    input logic              pad_pull_up,
    input logic              pad_pull_down,
    input logic              pad_keep,
    input logic              pad_val,
    input logic              pad_val_valid
);

    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst)
            cyc <= '0;
        else if (cyc != 2'd3)
            cyc <= cyc + 2'd1;
    end

    // R5: an illegal current request leaves the drive code alone
    assert_drv_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr && !ma_is_legal(reg_wdata[F_MA_LSB +: MA_W]))
        |=> $stable(pad_drv));

    assert_bias_onehot_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pad_pull_up, pad_pull_down, pad_keep}));

    assert_driven_level_R11: assert property (@(posedge clk) disable iff (rst)
        pad_oe |-> (pad_val_valid && pad_val == pad_out));

    assert_pull_down_R6: assert property (@(posedge clk) disable iff (rst)
        (!pad_oe && pad_pull_down) |-> (pad_val_valid && !pad_val));

    assert_pull_up_R6: assert property (@(posedge clk) disable iff (rst)
        (!pad_oe && pad_pull_up) |-> (pad_val_valid && pad_val));

    assert_no_pull_R8: assert property (@(posedge clk) disable iff (rst)
        (!pad_oe && !pad_pull_up && !pad_pull_down && !pad_keep) |-> !pad_val_valid);

    assert_keeper_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (cyc != 2'd0 && !pad_oe && pad_keep && $past(!pad_oe && pad_keep))
        |-> $stable(pad_val));

    if (STAGES == 2) begin : g_sync2
        assert_sync_delay_R9: assert property (@(posedge clk) disable iff (rst)
            (cyc >= 2'd2) |-> (in_sync == $past(pad_in, 2)));
    end

endmodule

bind pinpad_ctrl pinpad_ctrl_chk #(.STAGES(SYNC_STAGES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .pad_in        (pad_in),
    .in_sync       (in_sync),
    .pad_oe        (pad_oe),
    .pad_out       (pad_out),
    .pad_drv       (pad_drv),
    .pad_pull_up   (pad_pull_up),
    .pad_pull_down (pad_pull_down),
    .pad_keep      (pad_keep),
    .pad_val       (pad_val),
    .pad_val_valid (pad_val_valid)
);

// File: tb/pinpad_ctrl_test.sv
module pinpad_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [6:0]  alt_oe = '0;
    logic [6:0]  alt_out = '0;
    logic        pad_in = 1'b0;
    logic        in_sync, pad_oe, pad_out, pad_pull_up, pad_pull_down, pad_keep;
    logic        pad_val, pad_val_valid;
    logic [2:0]  pad_drv;

    int applied = 0;
    int failed  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    pinpad_ctrl uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .alt_oe(alt_oe), .alt_out(alt_out), .pad_in(pad_in), .in_sync(in_sync),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_drv(pad_drv),
        .pad_pull_up(pad_pull_up), .pad_pull_down(pad_pull_down), .pad_keep(pad_keep),
        .pad_val(pad_val), .pad_val_valid(pad_val_valid)
    );

    typedef struct packed {
        logic [15:0] ctl;
        logic        io_out;
        logic [6:0]  a_oe;
        logic [6:0]  a_out;
        logic        e_oe;
        logic        e_out;
        logic [2:0]  e_drv;
        logic        e_val;
        logic        e_valid;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0488, 1'b1, 7'h00, 7'h00, 1'b1, 1'b1, 3'd1, 1'b1, 1'b1},
        '{16'h0218, 1'b1, 7'h00, 7'h00, 1'b0, 1'b1, 3'd7, 1'b1, 1'b1},
        '{16'h010B, 1'b0, 7'h04, 7'h04, 1'b1, 1'b1, 3'd3, 1'b1, 1'b1},
        '{16'h0447, 1'b1, 7'h3F, 7'h7F, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0},
        '{16'h0159, 1'b0, 7'h01, 7'h00, 1'b1, 1'b0, 3'd4, 1'b0, 1'b1},
        '{16'h05CD, 1'b1, 7'h00, 7'h7F, 1'b0, 1'b1, 3'd6, 1'b0, 1'b1},
        '{16'h00C0, 1'b0, 7'h00, 7'h00, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        applied++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failed++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, r);
        check("R1 ctl", r, 16'h0048);
        check("R1 pad_oe", 16'(pad_oe), 16'd0);
        check("R1 drv", 16'(pad_drv), 16'd0);
        check("R1 val/valid", {14'd0, pad_val, pad_val_valid}, 16'h0001);

        // R2 R3 R4 R6 R8 R11 table
        for (int i = 0; i < NVEC; i++) begin
            alt_oe  = VECS[i].a_oe;
            alt_out = VECS[i].a_out;
            wr(1'b1, {15'd0, VECS[i].io_out});
            wr(1'b0, VECS[i].ctl);
            rd(1'b0, r);
            check("R2/R4 ctl readback", r, VECS[i].ctl);
            check("R2/R3 pad_oe", 16'(pad_oe), 16'(VECS[i].e_oe));
            check("R2/R3 pad_out", 16'(pad_out), 16'(VECS[i].e_out));
            check("R4 drv", 16'(pad_drv), 16'(VECS[i].e_drv));
            check("R6/R8/R11 valid", 16'(pad_val_valid), 16'(VECS[i].e_valid));
            if (VECS[i].e_valid)
                check("R6/R11 val", 16'(pad_val), 16'(VECS[i].e_val));
        end

        // R5: illegal current with new fields in the same write
        alt_oe = '0;
        wr(1'b0, 16'h0188);
        check("R4 drv 12mA", 16'(pad_drv), 16'd5);
        wr(1'b0, 16'h00BA);
        rd(1'b0, r);
        check("R5 odd request", r, 16'h019A);
        check("R5 odd drv", 16'(pad_drv), 16'd5);
        check("R12 pull-up decode", {13'd0, pad_pull_up, pad_pull_down, pad_keep}, 16'h0004);
        wr(1'b0, 16'h0001);
        rd(1'b0, r);
        check("R5 zero request", r, 16'h0181);
        wr(1'b0, 16'h0248);
        rd(1'b0, r);
        check("R5 over-range request", r, 16'h0188);
        check("R5 drv kept", 16'(pad_drv), 16'd5);
        check("R12 pull-down decode", {13'd0, pad_pull_up, pad_pull_down, pad_keep}, 16'h0002);
        wr(1'b0, 16'h0048);
        check("R4 drv 2mA", 16'(pad_drv), 16'd0);

        // R7 keeper
        wr(1'b1, 16'h0001);
        wr(1'b0, 16'h0450);
        check("R11 driven high", {14'd0, pad_val, pad_val_valid}, 16'h0003);
        wr(1'b0, 16'h0050);
        check("R12 keeper decode", {13'd0, pad_pull_up, pad_pull_down, pad_keep}, 16'h0001);
        check("R7 keeper after release", {14'd0, pad_val, pad_val_valid}, 16'h0003);
        wr(1'b1, 16'h0000);
        check("R7 keeper ignores gpio out", {14'd0, pad_val, pad_val_valid}, 16'h0003);
        wr(1'b0, 16'h0450);
        wr(1'b0, 16'h0050);
        check("R7 keeper holds low", {14'd0, pad_val, pad_val_valid}, 16'h0001);

        // R9 synchronizer under an alternate function
        wr(1'b0, 16'h0044);
        @(negedge clk);
        pad_in = 1'b1;
        @(negedge clk);
        check("R9 after one edge", 16'(in_sync), 16'd0);
        @(negedge clk);
        check("R9 after two edges", 16'(in_sync), 16'd1);
        rd(1'b1, r);
        check("R9 io readback", r, 16'h0002);

        // R10 read-only input bit
        pad_in = 1'b0;
        repeat (3) @(negedge clk);
        wr(1'b1, 16'h0002);
        rd(1'b1, r);
        check("R10 input bit not writable", r, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        $finish;
    end

endmodule